// File: doc/BRIEF.md
# Row-Column and Helical Interleaver Address Generator

This block produces the read-address sequence for a block interleaver whose storage holds a matrix of R rows by C columns, filled in row order. The linear address of the cell at row r and column c is therefore r*C + c. After a start request the block emits one read address on each cycle its enable is high. In one pass it visits every cell of the matrix once.

Two read orders are offered, chosen when the pass starts. The column order reads every row of column 0, then every row of column 1, and so on. The helical order walks the matrix diagonally. Read number k takes row k mod R and column ((k div R) + (k mod R)) mod C. The geometry is sampled at start and held for the whole pass. A geometry that cannot give a valid pass is rejected with a one-cycle error pulse, and no addresses are issued.

Top module: `intlv_addr_gen`

## Requirements
- R1: After reset, busy_o, done_o, cfg_err_o and addr_valid_o are all low.
- R2: With mode_i=0 (column order), read k of a pass presents addr_o = (k mod R)*C + (k div R).
- R3: With mode_i=1 (helical order), read k presents addr_o = (k mod R)*C + ((k div R) + (k mod R)) mod C.
- R4: An accepted pass issues exactly R*C addresses, each one below R*C, with no address repeated.
- R5: While busy_o is high, addr_valid_o follows en_i. A cycle with en_i low issues nothing, and the sequence does not advance.
- R6: busy_o rises in the cycle after an accepted start. It stays high until the last address has been issued. done_o is high for exactly one cycle, the cycle right after the last address, and busy_o is low in that cycle.
- R7: A start_i while busy_o is high is ignored. rows_i, cols_i and mode_i are captured only at an accepted start, and changes to them during a pass have no effect.
- R8: If rows_i or cols_i is below 2, or above MAX_ROWS or MAX_COLS respectively, cfg_err_o pulses for one cycle in the cycle after the start, and busy_o stays low.
- R9: In helical mode, an R and C that share a factor greater than 1 raise the same cfg_err_o pulse. In column mode, the same geometry is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Requests a new pass; acted on only when busy_o is low |
| mode_i | input | 1 | Read order: 0 selects column order, 1 selects helical order |
| rows_i | input | ROW_W | Number of matrix rows R |
| cols_i | input | COL_W | Number of matrix columns C |
| en_i | input | 1 | Advances the pass by one address when high |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse after the last address of a pass |
| cfg_err_o | output | 1 | One-cycle pulse when a start request is rejected |
| addr_valid_o | output | 1 | addr_o holds an address issued in this cycle |
| addr_o | output | ADDR_W | Read address, r*C + c |

## Verification
The start request is registered, so busy_o and the first address appear one edge after the start. The same holds for cfg_err_o on a rejected start. addr_o and addr_valid_o are combinational from the held counters and en_i, so address k can be read in the same cycle it is issued. done_o rises one edge after the last enabled read. The bench drives inputs and samples outputs on the falling edge, and applies a 1 ns settle time after changing en_i. Each check is placed at the edge count worked out above. Expected addresses come from the R2 and R3 formulas, and a per-pass table of seen addresses covers R4.

// File: rtl/intlv_pkg.sv
package intlv_pkg;
  typedef enum logic {
    MODE_COL   = 1'b0,
    MODE_HELIX = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/intlv_cfg_chk.sv
module intlv_cfg_chk
  import intlv_pkg::*;
#(
  parameter int MAX_ROWS = 16,
  parameter int MAX_COLS = 16,
  parameter int ROW_W    = 5,
  parameter int COL_W    = 5
) (
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  rd_mode_e         mode_i,
  output logic             cfg_ok_o
);
  localparam int MAX_DIM = (MAX_ROWS > MAX_COLS) ? MAX_ROWS : MAX_COLS;

  logic range_ok;
  logic common_factor;

  always_comb begin
    range_ok = (int'(rows_i) >= 2) && (int'(rows_i) <= MAX_ROWS) &&
               (int'(cols_i) >= 2) && (int'(cols_i) <= MAX_COLS);
    common_factor = 1'b0;
    // trial divisors: constant per iteration, no general divider
    for (int d = 2; d <= MAX_DIM; d++) begin
      if (((int'(rows_i) % d) == 0) && ((int'(cols_i) % d) == 0))
        common_factor = 1'b1;
    end
  end

  assign cfg_ok_o = range_ok && !((mode_i == MODE_HELIX) && common_factor);
endmodule

// File: rtl/intlv_seq.sv
module intlv_seq
  import intlv_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int COL_W = 5,
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  rd_mode_e         mode_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic             en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q, base_q;
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic [COL_W-1:0] base_nxt, col_inc;
  logic             busy_q, done_q;

  assign last_idx = CNT_W'(rows_i) * CNT_W'(cols_i) - CNT_W'(1);
  assign base_nxt = (base_q == cols_i - COL_W'(1)) ? '0 : base_q + COL_W'(1);
  assign col_inc  = (col_q  == cols_i - COL_W'(1)) ? '0 : col_q  + COL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch_i) begin
        busy_q <= 1'b1;
        row_q  <= '0;
        col_q  <= '0;
        base_q <= '0;
        cnt_q  <= '0;
      end else if (busy_q && en_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == last_idx) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        if (row_q == rows_i - ROW_W'(1)) begin
          // group of R reads complete: next column / next diagonal
          row_q  <= '0;
          base_q <= base_nxt;
          col_q  <= base_nxt;
        end else begin
          row_q <= row_q + ROW_W'(1);
          if (mode_i == MODE_HELIX) col_q <= col_inc;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
endmodule

// File: rtl/intlv_addr_map.sv
module intlv_addr_map #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5,
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 8
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  cols_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0] lin;

  assign lin    = CNT_W'(row_i) * CNT_W'(cols_i) + CNT_W'(col_i);
  assign addr_o = lin[ADDR_W-1:0];
endmodule

// File: rtl/intlv_addr_gen.sv
module intlv_addr_gen
  import intlv_pkg::*;
#(
  parameter int MAX_ROWS = 16,
  parameter int MAX_COLS = 16,
  localparam int ROW_W  = $clog2(MAX_ROWS + 1),
  localparam int COL_W  = $clog2(MAX_COLS + 1),
  localparam int CNT_W  = $clog2(MAX_ROWS * MAX_COLS + 1),
  localparam int ADDR_W = $clog2(MAX_ROWS * MAX_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic              en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ROW_W-1:0] rows_q;
  logic [COL_W-1:0] cols_q;
  rd_mode_e         mode_q;
  logic             cfg_err_q;
  logic             cfg_ok, accept, launch;
  logic [ROW_W-1:0] row_cur;
  logic [COL_W-1:0] col_cur;

  assign accept = start_i && !busy_o;
  assign launch = accept && cfg_ok;

  intlv_cfg_chk #(
    .MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) i_cfg_chk (
    .rows_i  (rows_i),
    .cols_i  (cols_i),
    .mode_i  (rd_mode_e'(mode_i)),
    .cfg_ok_o(cfg_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_q    <= '0;
      cols_q    <= '0;
      mode_q    <= MODE_COL;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= accept && !cfg_ok;
      if (launch) begin
        rows_q <= rows_i;
        cols_q <= cols_i;
        mode_q <= rd_mode_e'(mode_i);
      end
    end
  end

  intlv_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .mode_i  (mode_q),
    .rows_i  (rows_q),
    .cols_i  (cols_q),
    .en_i    (en_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .row_o   (row_cur),
    .col_o   (col_cur)
  );

  intlv_addr_map #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) i_addr_map (
    .row_i (row_cur),
    .col_i (col_cur),
    .cols_i(cols_q),
    .addr_o(addr_o)
  );

  assign addr_valid_o = busy_o && en_i;
  assign cfg_err_o    = cfg_err_q;
endmodule

// File: rtl/intlv_addr_gen_chk.sv
module intlv_addr_gen_chk #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              cfg_err_o,
  input logic              addr_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ROW_W-1:0]  rows_q,
  input logic [COL_W-1:0]  cols_q
);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_ends_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r5_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en_i) |=> (busy_o && $stable(addr_o)));

  a_r8_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!busy_o && !done_o));

  a_r4_addr_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (int'(addr_o) < int'(rows_q) * int'(cols_q)));

  a_r7_dims_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(rows_q) && $stable(cols_q)));
endmodule

bind intlv_addr_gen intlv_addr_gen_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cfg_err_o   (cfg_err_o),
  .addr_valid_o(addr_valid_o),
  .addr_o      (addr_o),
  .rows_q      (rows_q),
  .cols_q      (cols_q)
);

// File: tb/test_intlv_addr_gen.sv
`timescale 1ns/1ps
module test_intlv_addr_gen;
  localparam int MAX_ROWS = 16;
  localparam int MAX_COLS = 16;
  localparam int ROW_W  = $clog2(MAX_ROWS + 1);
  localparam int COL_W  = $clog2(MAX_COLS + 1);
  localparam int ADDR_W = $clog2(MAX_ROWS * MAX_COLS);
  localparam int NVEC   = 12;

  // {expect_err, mode, rows, cols}
  localparam logic [17:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 8'd4,  8'd4},
    {1'b0, 1'b1, 8'd3,  8'd4},
    {1'b0, 1'b1, 8'd5,  8'd7},
    {1'b0, 1'b0, 8'd2,  8'd16},
    {1'b0, 1'b1, 8'd16, 8'd15},
    {1'b1, 1'b1, 8'd4,  8'd6},
    {1'b0, 1'b0, 8'd4,  8'd6},
    {1'b1, 1'b0, 8'd1,  8'd5},
    {1'b1, 1'b1, 8'd17, 8'd3},
    {1'b1, 1'b0, 8'd3,  8'd0},
    {1'b1, 1'b1, 8'd2,  8'd2},
    {1'b0, 1'b0, 8'd16, 8'd16}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [ROW_W-1:0]  rows_i = '0;
  logic [COL_W-1:0]  cols_i = '0;
  logic              en_i = 1'b0;
  logic              busy_o, done_o, cfg_err_o, addr_valid_o;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  intlv_addr_gen #(.MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)) i_intlv_addr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .rows_i(rows_i), .cols_i(cols_i), .en_i(en_i), .busy_o(busy_o),
    .done_o(done_o), .cfg_err_o(cfg_err_o), .addr_valid_o(addr_valid_o),
    .addr_o(addr_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(input logic m, input int nr, input int nc, input int k);
    int r = k % nr;
    int c = m ? (((k / nr) + r) % nc) : (k / nr);
    return r * nc + c;
  endfunction

  task automatic run_pass(input logic m, input int nr, input int nc, input logic exp_err,
                          input int stall_k, input int poke_k);
    bit seen [MAX_ROWS*MAX_COLS];
    int distinct = 0;
    foreach (seen[i]) seen[i] = 1'b0;
    en_i = 1'b1; mode_i = m;
    rows_i = ROW_W'(nr); cols_i = COL_W'(nc);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (exp_err) begin
      check(cfg_err_o && !busy_o && !addr_valid_o, m ? "R9 reject" : "R8 reject",
            {cfg_err_o, busy_o}, 2);
      @(negedge clk_i);
      check(!cfg_err_o && !busy_o && !done_o, "R8 single err pulse, no pass",
            {cfg_err_o, busy_o, done_o}, 0);
      return;
    end
    check(busy_o && !cfg_err_o, "R6 busy after start", {busy_o, cfg_err_o}, 2);
    for (int k = 0; k < nr * nc; k++) begin
      int e = exp_addr(m, nr, nc, k);
      if (k == stall_k) begin
        en_i = 1'b0; #1;
        check(!addr_valid_o, "R5 stall no valid", addr_valid_o, 0);
        @(negedge clk_i);
        check(busy_o && !addr_valid_o && int'(addr_o) == e, "R5 stall holds sequence",
              int'(addr_o), e);
        en_i = 1'b1; #1;
      end
      if (k == poke_k) begin
        start_i = 1'b1; rows_i = ROW_W'(2); cols_i = COL_W'(3); mode_i = ~m;
      end else begin
        start_i = 1'b0;
      end
      check(addr_valid_o && busy_o && int'(addr_o) == e, m ? "R3 helical addr" : "R2 column addr",
            int'(addr_o), e);
      if (!seen[addr_o]) distinct++;
      else check(1'b0, "R4 repeated address", int'(addr_o), -1);
      seen[addr_o] = 1'b1;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(distinct == nr * nc, "R4 all addresses once", distinct, nr * nc);
    check(done_o && !busy_o, "R6 done after last", {done_o, busy_o}, 2);
    @(negedge clk_i);
    check(!done_o && !busy_o, "R6 done one cycle", {done_o, busy_o}, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL R6 watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
    #1;
    check(!busy_o && !done_o && !cfg_err_o && !addr_valid_o, "R1 reset outputs",
          {busy_o, done_o, cfg_err_o, addr_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !cfg_err_o && !addr_valid_o, "R1 idle after reset",
          {busy_o, done_o, cfg_err_o, addr_valid_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [17:0] v = VECS[i];
      run_pass(v[16], int'(v[15:8]), int'(v[7:0]), v[17], -1, -1);
    end

    // R5: stalls in both orders
    run_pass(1'b1, 3, 5, 1'b0, 4, -1);
    run_pass(1'b0, 4, 3, 1'b0, 11, -1);
    // R7: start and new geometry during a pass are ignored
    run_pass(1'b0, 4, 4, 1'b0, -1, 5);
    run_pass(1'b1, 5, 3, 1'b0, -1, 14);
    // R7: pass after the ignored request runs its own geometry
    run_pass(1'b1, 2, 3, 1'b0, -1, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule